// File: doc/BRIEF.md
# PMIC Register Bridge Controller

This controller gives a host processor access to the 16-bit registers of a power-management chip over a narrow serial link. The host sees a small register space. Writes that fall in a 4 KiB slave window are posted. Each one is queued as an address/data pair in an eight-entry FIFO, and the serial engine sends the queued pairs one by one. Reads are indirect. The host writes the wanted register address to a read-command register, which starts a serial read frame. The host then polls a read-data register until its busy bit drops.

The completed read word returns the 16-bit value together with the 12-bit register address that was sent on the wire. Software compares that echo with its request to catch a corrupted read. A pending read never overtakes a posted write, because it waits until the FIFO has drained. The FIFO status register shows the full flag, the empty flag, a sticky overflow flag and the fill level.

Top module: `pmic_bridge`

## Requirements
- R1: After reset the read-data word at offset 0x2C reads 0, the status word at offset 0x30 reads 0x400 (only the empty bit set), and the serial frame strobe is low.
- R2: A host write to offset 0x28 while not busy starts a read of address wdata[11:0]. Bit 31 of the read-data word reads 1 from the next cycle and stays 1 until that read frame has ended.
- R3: When the read completes, the read-data word holds the received value in bits 15:0, the requested address low 12 bits in bits 27:16, zeros in bits 30:28, and 0 in bit 31.
- R4: The status word has full in bit 11, empty in bit 10, sticky overflow in bit 9 and the fill level in bits 3:0, and full and empty are never both set.
- R5: A host write to an address from 0x8000 to 0x8FFF queues {addr[11:0], wdata[15:0]}, and the engine later sends it as a write frame. A write to any other address except 0x28 changes nothing.
- R6: The FIFO holds 8 entries. A window write while the FIFO is full is dropped and sets the overflow flag, which stays set until reset.
- R7: A frame is 29 bits sent MSB first while the strobe is high: a read/write bit (1 = read, 0 = write), 12 address bits, then 16 data bits. ser_dout changes only while ser_clk is low. For a read, ser_din is sampled on each of the 16 data bits before ser_clk falls.
- R8: A pending read frame starts only when the write FIFO is empty and the engine is idle, so a read returns data written by earlier posted writes.
- R9: A read command written while busy is set is ignored. It changes neither the requested address nor the result, and it starts no frame.
- R10: Host reads of offsets other than 0x2C and 0x30 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 16 | Host byte address for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| ser_frame | output | 1 | High for the whole of a serial transaction |
| ser_clk | output | 1 | Gated serial clock, one pulse per bit |
| ser_dout | output | 1 | Serial data to the slave |
| ser_din | input | 1 | Serial read data from the slave |

## Verification
Two functions can fall in the same cycle. One is the host pushing into the FIFO. The other is the engine popping the head entry to start a frame. The bench provokes this with ten back-to-back window writes on an idle engine, so the second push lands on the cycle of the first pop. The level, full and overflow bits read afterwards must then show eight entries and exactly one drop. The read-command path also meets the FIFO drain: a read issued right behind two posted writes must come back with the second write's data and its echoed address.

// File: rtl/pmic_bridge.sv
module pmic_bridge #(
  parameter int FIFO_DEPTH = 8,
  parameter logic [3:0] WIN_PAGE = 4'h8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [15:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        ser_frame,
  output logic        ser_clk,
  output logic        ser_dout,
  input  logic        ser_din
);
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int FRAME = 1 + AW + DW;
  localparam int CW = $clog2(FRAME);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int LW = $clog2(FIFO_DEPTH + 1);
  localparam logic [15:0] OFS_CMD = 16'h0028;
  localparam logic [15:0] OFS_DATA = 16'h002C;
  localparam logic [15:0] OFS_STS = 16'h0030;

  logic [AW+DW-1:0] fifo_q [FIFO_DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [LW-1:0]    lvl;
  logic             ovf, busy, rd_pend, active, ph, is_rd;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    rd_val;
  logic [FRAME-1:0] sh;
  logic [CW-1:0]    cnt;

  wire win_hit  = host_addr[15:12] == WIN_PAGE;
  wire full     = lvl == LW'(FIFO_DEPTH);
  wire empty    = lvl == '0;
  wire push     = host_we && win_hit && !full;
  wire pop      = !active && !empty;
  wire start_rd = !active && empty && rd_pend;
  wire rd_cmd   = host_we && host_addr == OFS_CMD && !busy;
  wire last_bit = active && ph && cnt == CW'(FRAME - 1);

  assign ser_frame = active;
  assign ser_clk   = active & ph;
  assign ser_dout  = active & sh[FRAME-1];

  always_ff @(posedge clk)
    if (push) fifo_q[wp] <= {host_addr[AW-1:0], host_wdata[DW-1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; lvl <= '0; ovf <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      lvl <= lvl + LW'(push) - LW'(pop);
      if (host_we && win_hit && full) ovf <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; rd_pend <= 1'b0; rd_addr <= '0; rd_val <= '0;
      active <= 1'b0; ph <= 1'b0; is_rd <= 1'b0; sh <= '0; cnt <= '0;
    end else begin
      if (rd_cmd) begin
        busy <= 1'b1;
        rd_pend <= 1'b1;
        rd_addr <= host_wdata[AW-1:0];
      end
      if (pop) begin
        sh <= {1'b0, fifo_q[rp]};
        active <= 1'b1; is_rd <= 1'b0; ph <= 1'b0; cnt <= '0;
      end else if (start_rd) begin
        sh <= {1'b1, rd_addr, {DW{1'b0}}};
        active <= 1'b1; is_rd <= 1'b1; ph <= 1'b0; cnt <= '0;
        rd_pend <= 1'b0;
      end else if (active) begin
        ph <= ~ph;
        if (ph) begin
          sh <= {sh[FRAME-2:0], ser_din};
          cnt <= cnt + 1'b1;
          if (last_bit) begin
            active <= 1'b0;
            if (is_rd) begin
              rd_val <= {sh[DW-2:0], ser_din};
              busy <= 1'b0;
            end
          end
        end
      end
    end

  always_comb begin
    host_rdata = '0;
    if (host_addr == OFS_DATA)
      host_rdata = {busy, 3'b000, rd_addr, rd_val};
    else if (host_addr == OFS_STS) begin
      host_rdata[11] = full;
      host_rdata[10] = empty;
      host_rdata[9] = ovf;
      host_rdata[LW-1:0] = lvl;
    end
  end
endmodule

module pmic_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [15:0] host_addr,
  input logic        win_hit,
  input logic        busy,
  input logic        full,
  input logic        empty,
  input logic        ovf,
  input logic        ser_frame,
  input logic        ser_clk,
  input logic        ser_dout
);
  // R2
  rd_cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_addr == 16'h0028 && !busy |=> busy);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ser_frame |=> busy);
  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && win_hit && full |=> ovf);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R7
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> ser_frame);
  // R7
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk && ser_frame |-> $stable(ser_dout));
  // R8
  read_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_frame) && ser_dout |-> empty);
endmodule

bind pmic_bridge pmic_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .win_hit(win_hit), .busy(busy), .full(full), .empty(empty), .ovf(ovf),
  .ser_frame(ser_frame), .ser_clk(ser_clk), .ser_dout(ser_dout)
);

// File: tb/sim_pmic_bridge.sv
`timescale 1ns/1ps
module sim_pmic_bridge;
  logic clk = 0, rst_n = 0, host_we = 0, ser_din = 0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic ser_frame, ser_clk, ser_dout;
  int checks = 0, errors = 0, frames = 0, nb = 0, last_bits = 0;
  logic [28:0] rx;
  logic [12:0] hdr, last_hdr;
  logic [15:0] mem [4096];
  bit done = 0;

  always #5 clk = ~clk;

  pmic_bridge u0 (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ser_frame(ser_frame),
    .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din));

  initial for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h3C5A;

  always @(posedge ser_frame) nb = 0;
  always @(posedge ser_clk) begin
    rx = {rx[27:0], ser_dout};
    if (nb == 12) hdr = rx[12:0];
    if (nb >= 13 && hdr[12]) ser_din = mem[hdr[11:0]][28 - nb];
    nb++;
  end
  always @(negedge ser_frame) begin
    if (!hdr[12]) mem[hdr[11:0]] = rx[15:0];
    last_bits = nb; last_hdr = hdr; frames++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0; host_addr = 16'h0;
  endtask

  task automatic hread(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s, r;
    for (int i = 0; i < 2000; i++) begin
      hread(16'h0030, s); hread(16'h002C, r);
      if (s[10] && !r[31] && !ser_frame) return;
    end
    chk(0, "idle wait", 0, 1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hread(16'h002C, d); chk(d == 0, "R1 rdata", d, 0);
    hread(16'h0030, d); chk(d == 32'h400, "R1 status", d, 32'h400);
    chk(ser_frame == 0, "R1 frame", 32'(ser_frame), 0);
  endtask

  task automatic t_read(input logic [11:0] a);
    logic [31:0] d, e;
    hwrite(16'h0028, {20'hFFFF0, a});
    hread(16'h002C, d); chk(d[31], "R2 busy set", d, 32'h80000000);
    wait_idle();
    e = {4'b0, a, mem[a]};
    hread(16'h002C, d); chk(d == e, "R3 read word", d, e);
    chk(last_bits == 29 && last_hdr == {1'b1, a}, "R7 read frame", {last_bits[15:0], 3'b0, last_hdr}, {16'd29, 3'b0, 1'b1, a});
  endtask

  task automatic t_write();
    logic [31:0] d;
    hwrite(16'h8010, 32'h1234BEEF);
    wait_idle();
    chk(mem[12'h010] == 16'hBEEF, "R5 posted write", 32'(mem[12'h010]), 32'hBEEF);
    chk(last_bits == 29 && last_hdr == 13'h0010, "R7 write frame", {last_bits[15:0], 3'b0, last_hdr}, {16'd29, 16'h0010});
    t_read(12'h010);
    hwrite(16'h9010, 32'h5555);
    hwrite(16'h0040, 32'h5555);
    hread(16'h0030, d); chk(d == 32'h400, "R5 outside window ignored", d, 32'h400);
    repeat (4) @(negedge clk);
    chk(ser_frame == 0 && mem[12'h010] == 16'hBEEF, "R5 no frame from outside", 32'(mem[12'h010]), 32'hBEEF);
    hread(16'h1234, d); chk(d == 0, "R10 other offset", d, 0);
    hread(16'h8010, d); chk(d == 0, "R10 window read", d, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); host_we = 1; host_addr = 16'h8200 + 16'(i); host_wdata = 32'hA000 + i;
    end
    @(negedge clk); host_we = 0; host_addr = 0;
    hread(16'h0030, d); chk(d == 32'hA08, "R4 R6 full overflow level", d, 32'hA08);
    wait_idle();
    chk(mem[12'h208] == 16'hA008, "R6 last accepted", 32'(mem[12'h208]), 32'hA008);
    chk(mem[12'h209] == (16'(12'h209 * 16'h0101) ^ 16'h3C5A), "R6 dropped entry", 32'(mem[12'h209]),
        32'(16'(12'h209 * 16'h0101) ^ 16'h3C5A));
    hread(16'h0030, d); chk(d == 32'h600, "R6 sticky overflow", d, 32'h600);
  endtask

  task automatic t_order();
    logic [31:0] d;
    hwrite(16'h8054, 32'h1111);
    hwrite(16'h8055, 32'h5A5A);
    hwrite(16'h0028, 32'h055);
    wait_idle();
    hread(16'h002C, d); chk(d == 32'h00555A5A, "R8 read after drain", d, 32'h00555A5A);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d, e;
    int f0;
    f0 = frames;
    hwrite(16'h0028, 32'hABC);
    hwrite(16'h0028, 32'h111);
    wait_idle();
    repeat (70) @(negedge clk);
    e = {4'b0, 12'hABC, mem[12'hABC]};
    hread(16'h002C, d); chk(d == e, "R9 second command ignored", d, e);
    chk(frames == f0 + 1, "R9 one frame", 32'(frames), 32'(f0 + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_read(12'h123);
    t_read(12'hFFF);
    t_write();
    t_overflow();
    t_order();
    t_busy_ignore();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule